// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits at the execute stage of a five-stage in-order pipeline. It decides where each of the two ALU operands comes from. One choice is the register value captured when the instruction left decode. The others are the ALU result of the older instruction now one stage ahead in the memory stage, or the value that the instruction two stages ahead is about to write back. For each operand it outputs a 2-bit source code and the chosen data word. The two operands are decided separately.

The writeback value is either the load data or the ALU result, picked by a per-instruction "result from memory" flag. The block outputs that value so the rest of the pipeline can use it.

All clocking in the pipeline is on rising edges only, so the register file is written and read on the same edge. For that reason the block also has a decode-side bypass. When writeback targets the register that decode is reading, the decode read returns the writeback value and not the stale array content. The block is purely combinational.

Top module: `operand_bypass`

## Requirements
- R1: When neither older stage supplies a source register, its select code is 2'b00 and the operand equals the register value latched at decode.
- R2: When the memory-stage instruction writes (write flag 1) a nonzero destination equal to the source register, the select code is 2'b10 and the operand equals the memory-stage ALU result.
- R3: When only the writeback-stage instruction writes a nonzero destination equal to the source register, the select code is 2'b01 and the operand equals the writeback value.
- R4: When both older stages match the same source register, the memory stage wins (code 2'b10, memory-stage result).
- R5: Register number 0 is never forwarded: a source or destination of 0 gives code 2'b00 and the latched register value, whatever the write flags are.
- R6: A stage whose write flag is 0 never supplies an operand, even when its destination matches.
- R7: The writeback value equals the load data when the result-from-memory flag is 1, and the writeback ALU result when it is 0.
- R8: A decode-side read returns the writeback value when writeback writes a nonzero register equal to the read register number. Otherwise it returns the raw register-file read data.
- R9: The select code is never 2'b11, and each operand's selection depends only on its own source register number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | RW | Execute-stage first source register number |
| ex_src_b | input | RW | Execute-stage second source register number |
| mem_dst | input | RW | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| wb_dst | input | RW | Destination register of the writeback-stage instruction |
| wb_wen | input | 1 | Writeback-stage instruction writes a register |
| wb_from_load | input | 1 | Writeback result comes from memory data |
| rf_val_a | input | DW | First operand latched at decode |
| rf_val_b | input | DW | Second operand latched at decode |
| mem_result | input | DW | Memory-stage ALU result |
| wb_alu | input | DW | Writeback-stage ALU result |
| wb_load | input | DW | Writeback-stage load data |
| dec_src_a | input | RW | Decode first read register number |
| dec_src_b | input | RW | Decode second read register number |
| dec_raw_a | input | DW | Register-file array read data, first port |
| dec_raw_b | input | DW | Register-file array read data, second port |
| sel_a | output | 2 | Source code for the first operand |
| sel_b | output | 2 | Source code for the second operand |
| opnd_a | output | DW | Forwarded first operand |
| opnd_b | output | DW | Forwarded second operand |
| wb_value | output | DW | Value written back this cycle |
| dec_val_a | output | DW | Bypassed decode read, first port |
| dec_val_b | output | DW | Bypassed decode read, second port |

## Verification
The bench builds the block with RW=3 and DW=8, so the register space has eight entries. That makes it practical to enumerate every combination of both source numbers, both destination numbers and both write flags. The sweep therefore reaches every case where register 0 collides with a destination, every case where both stages match (priority), and every case where only one operand matches. Each data input carries a distinct constant, so a wrong mux choice shows up as a wrong value. The load-select flag alternates through the sweep so both writeback sources are seen.

// File: rtl/operand_bypass.sv
module operand_bypass #(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input  logic [RW-1:0] ex_src_a,
  input  logic [RW-1:0] ex_src_b,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wen,
  input  logic [RW-1:0] wb_dst,
  input  logic          wb_wen,
  input  logic          wb_from_load,
  input  logic [DW-1:0] rf_val_a,
  input  logic [DW-1:0] rf_val_b,
  input  logic [DW-1:0] mem_result,
  input  logic [DW-1:0] wb_alu,
  input  logic [DW-1:0] wb_load,
  input  logic [RW-1:0] dec_src_a,
  input  logic [RW-1:0] dec_src_b,
  input  logic [DW-1:0] dec_raw_a,
  input  logic [DW-1:0] dec_raw_b,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b,
  output logic [DW-1:0] wb_value,
  output logic [DW-1:0] dec_val_a,
  output logic [DW-1:0] dec_val_b
);

  localparam logic [1:0] SEL_REG = 2'b00;
  localparam logic [1:0] SEL_MEM = 2'b10;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam logic [RW-1:0] REG_ZERO = '0;

  logic mem_live, wb_live;
  assign mem_live = mem_wen && (mem_dst != REG_ZERO);
  assign wb_live  = wb_wen  && (wb_dst  != REG_ZERO);

  assign wb_value = wb_from_load ? wb_load : wb_alu;

  assign sel_a = (mem_live && mem_dst == ex_src_a) ? SEL_MEM :
                 (wb_live  && wb_dst  == ex_src_a) ? SEL_WB  : SEL_REG;
  assign sel_b = (mem_live && mem_dst == ex_src_b) ? SEL_MEM :
                 (wb_live  && wb_dst  == ex_src_b) ? SEL_WB  : SEL_REG;

  always_comb begin
    unique case (sel_a)
      SEL_MEM: opnd_a = mem_result;
      SEL_WB:  opnd_a = wb_value;
      default: opnd_a = rf_val_a;
    endcase
    unique case (sel_b)
      SEL_MEM: opnd_b = mem_result;
      SEL_WB:  opnd_b = wb_value;
      default: opnd_b = rf_val_b;
    endcase
  end

  assign dec_val_a = (wb_live && wb_dst == dec_src_a) ? wb_value : dec_raw_a;
  assign dec_val_b = (wb_live && wb_dst == dec_src_b) ? wb_value : dec_raw_b;

  always_comb begin
    if (!$isunknown({ex_src_a, ex_src_b, mem_dst, mem_wen, wb_dst, wb_wen})) begin
      a_r9_no_illegal_code: assert (sel_a != 2'b11 && sel_b != 2'b11);
      if (ex_src_a == REG_ZERO)
        a_r5_zero_stays_local: assert (sel_a == SEL_REG);
      if (!mem_wen && !wb_wen)
        a_r6_no_writer_no_bypass: assert (sel_a == SEL_REG && sel_b == SEL_REG);
      if (mem_live && mem_dst == ex_src_b)
        a_r4_newest_wins: assert (sel_b == SEL_MEM);
    end
    if (!$isunknown({sel_a, rf_val_a}) && sel_a == SEL_REG)
      a_r1_local_value: assert (opnd_a == rf_val_a);
    if (!$isunknown({wb_wen, wb_dst, dec_src_a, wb_value, dec_val_a})
        && wb_wen && wb_dst != REG_ZERO && wb_dst == dec_src_a)
      a_r8_same_edge_read: assert (dec_val_a == wb_value);
  end

endmodule

// File: tb/tb_operand_bypass.sv
module tb_operand_bypass;
  localparam int DW = 8;
  localparam int RW = 3;
  localparam int NR = 1 << RW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [RW-1:0] ex_src_a, ex_src_b, mem_dst, wb_dst, dec_src_a, dec_src_b;
  logic mem_wen, wb_wen, wb_from_load;
  logic [DW-1:0] rf_val_a, rf_val_b, mem_result, wb_alu, wb_load, dec_raw_a, dec_raw_b;
  logic [1:0] sel_a, sel_b;
  logic [DW-1:0] opnd_a, opnd_b, wb_value, dec_val_a, dec_val_b;

  operand_bypass #(.DW(DW), .RW(RW)) dut (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .mem_dst(mem_dst), .mem_wen(mem_wen),
    .wb_dst(wb_dst), .wb_wen(wb_wen), .wb_from_load(wb_from_load),
    .rf_val_a(rf_val_a), .rf_val_b(rf_val_b), .mem_result(mem_result),
    .wb_alu(wb_alu), .wb_load(wb_load), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .dec_raw_a(dec_raw_a), .dec_raw_b(dec_raw_b), .sel_a(sel_a), .sel_b(sel_b),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .wb_value(wb_value),
    .dec_val_a(dec_val_a), .dec_val_b(dec_val_b));

  int total = 0;
  int fails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string tag_for(int s, int md, int mw, int wd, int ww);
    bit m = mw != 0 && md != 0 && md == s;
    bit w = ww != 0 && wd != 0 && wd == s;
    if (s == 0) return "R5";
    if (m && w) return "R4";
    if (m) return "R2";
    if (w) return "R3";
    if ((md == s && mw == 0) || (wd == s && ww == 0)) return "R6";
    return "R1";
  endfunction

  initial begin
    ex_src_a = '0; ex_src_b = '0; mem_dst = '0; wb_dst = '0;
    dec_src_a = '0; dec_src_b = '0;
    mem_wen = 0; wb_wen = 0; wb_from_load = 0;
    rf_val_a = 8'h11; rf_val_b = 8'h22; mem_result = 8'h33;
    wb_alu = 8'h44; wb_load = 8'h55; dec_raw_a = 8'h66; dec_raw_b = 8'h77;
    @(negedge clk);
    check(sel_a == 2'b00 && sel_b == 2'b00, "R1 idle codes", {sel_a, sel_b}, 0);
    check(opnd_a == 8'h11 && opnd_b == 8'h22, "R1 idle operands", {opnd_a, opnd_b}, 16'h1122);

    for (int idx = 0; idx < NR * NR * NR * NR * 4; idx++) begin
      int sa, sb, md, wd, mw, ww, ld;
      int exp_wb, exp_sa, exp_sb, exp_oa, exp_ob, exp_da, exp_db;
      sa = idx % NR; sb = (idx / NR) % NR; md = (idx / (NR * NR)) % NR;
      wd = (idx / (NR * NR * NR)) % NR; mw = (idx / (NR * NR * NR * NR)) % 2;
      ww = (idx / (NR * NR * NR * NR * 2)) % 2; ld = (idx / 3) % 2;
      @(posedge clk);
      ex_src_a = sa[RW-1:0]; ex_src_b = sb[RW-1:0];
      mem_dst = md[RW-1:0]; wb_dst = wd[RW-1:0];
      mem_wen = mw[0]; wb_wen = ww[0]; wb_from_load = ld[0];
      dec_src_a = sb[RW-1:0]; dec_src_b = sa[RW-1:0];
      @(negedge clk);
      exp_wb = ld ? 'h55 : 'h44;
      exp_sa = (mw && md != 0 && md == sa) ? 2 : (ww && wd != 0 && wd == sa) ? 1 : 0;
      exp_sb = (mw && md != 0 && md == sb) ? 2 : (ww && wd != 0 && wd == sb) ? 1 : 0;
      exp_oa = exp_sa == 2 ? 'h33 : exp_sa == 1 ? exp_wb : 'h11;
      exp_ob = exp_sb == 2 ? 'h33 : exp_sb == 1 ? exp_wb : 'h22;
      exp_da = (ww && wd != 0 && wd == sb) ? exp_wb : 'h66;
      exp_db = (ww && wd != 0 && wd == sa) ? exp_wb : 'h77;
      check(wb_value == exp_wb[DW-1:0], "R7 writeback source", wb_value, exp_wb);
      check(sel_a == exp_sa[1:0] && opnd_a == exp_oa[DW-1:0],
            {tag_for(sa, md, mw, wd, ww), " operand a R9"}, {sel_a, opnd_a}, (exp_sa << 8) | exp_oa);
      check(sel_b == exp_sb[1:0] && opnd_b == exp_ob[DW-1:0],
            {tag_for(sb, md, mw, wd, ww), " operand b R9"}, {sel_b, opnd_b}, (exp_sb << 8) | exp_ob);
      check(dec_val_a == exp_da[DW-1:0] && dec_val_b == exp_db[DW-1:0],
            "R8 decode bypass", {dec_val_a, dec_val_b}, (exp_da << 8) | exp_db);
    end
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule